// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block brings a processor core out of its low-power stop state. A stop request from the core gates the core clock. Depending on configuration, the request also powers down the on-chip oscillator and the clock multiplier PLL. When an external wake interrupt arrives during stop, the block powers the clock sources back up. It then holds the core until every wait that applies has ended, and issues a single pulse that starts the first instruction fetch.

Three configuration bits decide which waits apply: the clock source select, the keep-active bit for the oscillator and PLL during stop, and the stop-delay disable. A PLL-enabled flag is a fourth input to the same decision. The stabilization counter and the PLL relock wait run at the same time, so the wake-up ends when the later of the two finishes. All four bits are captured when the block enters stop. The stabilization length is the parameter `DELAY_CYCLES`, which defaults to 131072 cycles.

Top module: `stop_wake_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `osc_pd` and `pll_pd` are 0, `core_clk_en` is 1 and `fetch_start` is 0.
- R2: A 1 on `stop_req` in the running state drops `core_clk_en` after the next clock edge. The core stays stopped, with no `fetch_start`, until a wake is seen.
- R3: In stop, `osc_pd` is 1 exactly when `cfg_keep_on`=0 and `cfg_ext_clk`=0. In stop, `pll_pd` is 1 exactly when `pll_en`=1 and `cfg_keep_on`=0. Both return to 0 once the wake sequence starts, and neither is ever 1 while `core_clk_en` is 1.
- R4: `wake_irq` passes through a two-flop synchronizer, so the wait begins on the third edge after it rises. A wake while the core runs has no effect.
- R5: With `cfg_keep_on`=1 there is no stabilization delay and no relock wait, and `cfg_nodelay` is ignored. `fetch_start` appears 4 edges after `wake_irq` rises.
- R6: With `cfg_ext_clk`=0, `cfg_keep_on`=0 and `cfg_nodelay`=0, the wait lasts `DELAY_CYCLES` cycles.
- R7: `cfg_nodelay`=1 skips the stabilization counter.
- R8: `cfg_ext_clk`=1 removes the stabilization delay. The relock wait still follows `pll_en` and `cfg_keep_on`.
- R9: With `pll_en`=1 and `cfg_keep_on`=0, the fetch waits for `pll_locked`. The relock wait and the counter run in parallel, so the wait lasts as long as the longer of the two.
- R10: `fetch_start` is a single-cycle pulse. `core_clk_en` is 1 during that pulse and afterwards, as the block returns to running.
- R11: The four configuration inputs are captured on entry to stop. Changes to them during stop do not alter the current wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Core requests stop |
| wake_irq | input | 1 | External wake interrupt (asynchronous) |
| cfg_ext_clk | input | 1 | 1 = external clock source, 0 = internal oscillator |
| cfg_keep_on | input | 1 | 1 = oscillator and PLL stay active in stop |
| cfg_nodelay | input | 1 | 1 = skip the stabilization counter |
| pll_en | input | 1 | PLL is in use |
| pll_locked | input | 1 | PLL lock indication |
| osc_pd | output | 1 | Oscillator power-down |
| pll_pd | output | 1 | PLL power-down |
| core_clk_en | output | 1 | Core clock enable |
| fetch_start | output | 1 | One-cycle pulse that releases the first fetch |

## Verification
The assertions check several rules on every cycle: the power-downs never overlap a running clock, the fetch pulse lasts one cycle, a fetch after a counted delay comes only when the counter has reached its limit, a fetch that needs relock comes only after lock was seen, and the captured configuration stays steady through stop. Only the bench scenarios can show the wake latency for each configuration, the choice of the longer of the counter and the relock, the ignored wake while running, and the effect of changing the configuration during stop. The bench measures these against a PLL model with a programmable lock time.

// File: rtl/stop_wake_seq.sv
module stop_wake_seq #(
  parameter int unsigned DELAY_CYCLES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic cfg_ext_clk,
  input  logic cfg_keep_on,
  input  logic cfg_nodelay,
  input  logic pll_en,
  input  logic pll_locked,
  output logic osc_pd,
  output logic pll_pd,
  output logic core_clk_en,
  output logic fetch_start
);

  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] DLIM = CW'(DELAY_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WAIT, S_RESUME} st_t;

  st_t state;
  logic wk_s1, wk_s2;
  logic ext_q, keep_q, nodly_q, plle_q;
  logic [CW-1:0] cnt;

  wire need_delay = !keep_q && !nodly_q && !ext_q;
  wire need_lock  = plle_q && !keep_q;
  wire delay_done = !need_delay || (cnt == DLIM);
  wire lock_done  = !need_lock || pll_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_s1 <= 1'b0;
      wk_s2 <= 1'b0;
    end else begin
      wk_s1 <= wake_irq;
      wk_s2 <= wk_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      keep_q  <= 1'b0;
      nodly_q <= 1'b0;
      plle_q  <= 1'b0;
    end else if (state == S_RUN && stop_req) begin
      ext_q   <= cfg_ext_clk;
      keep_q  <= cfg_keep_on;
      nodly_q <= cfg_nodelay;
      plle_q  <= pll_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        S_RUN:    if (stop_req) state <= S_STOP;
        S_STOP: begin
          cnt <= '0;
          if (wk_s2) state <= S_WAIT;
        end
        S_WAIT: begin
          if (!delay_done) cnt <= cnt + 1'b1;
          if (delay_done && lock_done) state <= S_RESUME;
        end
        default: begin
          cnt   <= '0;
          state <= S_RUN;
        end
      endcase
    end
  end

  assign osc_pd      = (state == S_STOP) && !keep_q && !ext_q;
  assign pll_pd      = (state == S_STOP) && need_lock;
  assign core_clk_en = (state == S_RUN) || (state == S_RESUME);
  assign fetch_start = (state == S_RESUME);

  a_r3_pd_clk_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_pd || pll_pd) |-> !core_clk_en);

  a_r10_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> (!fetch_start && core_clk_en));

  a_r6_delay_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && need_delay) |-> ($past(cnt) == DLIM));

  a_r9_lock_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && need_lock) |-> $past(pll_locked));

  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN && $past(state) != S_RUN) |-> $stable({ext_q, keep_q, nodly_q, plle_q}));

endmodule

// File: tb/stop_wake_seq_test.sv
module stop_wake_seq_test;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wake_irq = 1'b0;
  logic cfg_ext_clk = 1'b0, cfg_keep_on = 1'b0, cfg_nodelay = 1'b0, pll_en = 1'b0;
  logic pll_locked = 1'b1;
  logic osc_pd, pll_pd, core_clk_en, fetch_start;

  int checks = 0, errors = 0;
  int lock_lat = 1;
  int lcnt = 1000;

  always #5 clk = ~clk;

  stop_wake_seq #(.DELAY_CYCLES(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
    .cfg_ext_clk(cfg_ext_clk), .cfg_keep_on(cfg_keep_on), .cfg_nodelay(cfg_nodelay),
    .pll_en(pll_en), .pll_locked(pll_locked), .osc_pd(osc_pd), .pll_pd(pll_pd),
    .core_clk_en(core_clk_en), .fetch_start(fetch_start));

  always @(negedge clk) begin
    if (pll_pd) lcnt = 0;
    else if (lcnt < 1000) lcnt++;
    pll_locked = !pll_pd && (lcnt >= lock_lat);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wake_case(input string req, input logic ext, input logic keep,
                           input logic nodly, input logic plle, input int lat,
                           input bit flip);
    int dd, ll, expl, n;
    lock_lat = lat;
    @(negedge clk);
    cfg_ext_clk = ext; cfg_keep_on = keep; cfg_nodelay = nodly; pll_en = plle;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk({req, "/R2 clk gated"}, core_clk_en, 0);
    chk({req, "/R3 osc_pd"}, osc_pd, (!keep && !ext) ? 1 : 0);
    chk({req, "/R3 pll_pd"}, pll_pd, (plle && !keep) ? 1 : 0);
    if (flip) begin
      cfg_keep_on = 1'b1; cfg_nodelay = 1'b1; cfg_ext_clk = 1'b1; pll_en = 1'b0;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fetch_start || core_clk_en) chk({req, "/R2 stays stopped"}, 1, 0);
    end
    dd = (!keep && !nodly && !ext) ? DLY : 0;
    ll = (plle && !keep) ? lat : 0;
    expl = 3 + ((dd > ll) ? ((dd > 1) ? dd : 1) : ((ll > 1) ? ll : 1));
    wake_irq = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) chk({req, "/R3 pd released"}, {osc_pd, pll_pd}, 0);
    end while (!fetch_start && n < 300);
    wake_irq = 1'b0;
    chk({req, "/latency"}, n, expl);
    chk({req, "/R10 clk on at fetch"}, core_clk_en, 1);
    @(negedge clk);
    chk({req, "/R10 pulse one cycle"}, fetch_start, 0);
    chk({req, "/R10 running"}, core_clk_en, 1);
    cfg_keep_on = 1'b0; cfg_nodelay = 1'b0; cfg_ext_clk = 1'b0; pll_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_wake_ignored();
    @(negedge clk);
    wake_irq = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 wake in run: no fetch", fetch_start, 0);
      chk("R4 wake in run: clk on", core_clk_en, 1);
    end
    wake_irq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 osc_pd", osc_pd, 0);
    chk("R1 pll_pd", pll_pd, 0);
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 fetch", fetch_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {osc_pd, pll_pd, core_clk_en, fetch_start}, 4'b0010);

    wake_case("R5 keep on", 0, 1, 0, 1, 30, 0);
    wake_case("R5 keep on, nodelay ignored", 0, 1, 1, 1, 30, 0);
    wake_case("R6 delay only", 0, 0, 0, 0, 1, 0);
    wake_case("R7 delay skipped", 0, 0, 1, 0, 1, 0);
    wake_case("R8 external clock", 1, 0, 0, 0, 1, 0);
    wake_case("R9 lock shorter than delay", 0, 0, 0, 1, 5, 0);
    wake_case("R9 lock longer than delay", 0, 0, 0, 1, 35, 0);
    wake_case("R8 R9 external clock relock", 1, 0, 0, 1, 12, 0);
    wake_case("R9 lock only, delay skipped", 0, 0, 1, 1, 7, 0);
    wake_case("R11 cfg changed in stop", 0, 0, 0, 1, 35, 1);
    run_wake_ignored();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule